// File: doc/BRIEF.md
# Two-Source Interrupt Flag and Enable Controller

This block gathers two interrupt causes into one active-low request line. The first cause is an edge on an external control line. The line passes through a synchronizer, and a control register selects whether a rising or a falling edge counts. The second cause is a one-cycle pulse that signals the end of a shift sequence. The shifting logic lives outside the block.

Each cause has a sticky flag and an enable bit. Software accesses the block through a byte-wide register bus that uses a 2-bit address. The enable register is written in set/clear style: bit 7 of the written byte selects whether the other written ones set enables or clear them. A flag is cleared by writing a one to its bit.

Reading the shift data address has two side effects. It clears the shift-complete flag, and it emits a one-cycle pulse that starts the next shift sequence. This lets a single read both acknowledge a received byte and re-arm the shifter.

Top module: `irq_ctl`

Address map (`addr_i`): 0 = shift data, 1 = control, 2 = flags, 3 = enables. Flag and enable bit 2 belong to the shift-complete source, and bit 3 belongs to the control-line edge source. All other bits from 0 to 6 read as 0.

## Requirements
- R1: A write to address 3 with bit 7 = 1 sets every enable whose bit is written as 1. Bits written as 0 keep their value.
- R2: A write to address 3 with bit 7 = 0 clears every enable whose bit is written as 1. Bits written as 0 keep their value.
- R3: Reading address 3 returns bit 7 = 1, the enables in bits 2 and 3, and zeros elsewhere.
- R4: Flag bit 2 is set by a `shift_done_i` pulse. Flag bit 3 is set by the selected edge of `line_i`. Reading address 2 returns the flags in bits 0 to 6, and bit 7 is the OR of all flags whose enable is set.
- R5: A write to address 2 clears each flag whose bit is written as 1. Bits written as 0 are left unchanged.
- R6: Control bit 6 = 0 makes the edge flag respond to falling edges of `line_i`. A control value of 0x20 therefore selects falling edges. Control bit 6 = 1 selects rising edges. Address 1 reads back the full control byte.
- R7: A read of address 0 returns `shift_data_i`. It clears flag bit 2 and raises `shift_start_o` for exactly one cycle, in the cycle after the read edge.
- R8: `irq_no` is low exactly when at least one flag is set together with its enable.
- R9: If a set event and a clearing write or read reach the same flag in the same cycle, the flag ends up set.
- R10: After reset, all flags, enables and the control byte are 0, `irq_no` is high and `shift_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; only the side effects of a read use it |
| line_i | input | 1 | Asynchronous control line, idle high |
| shift_done_i | input | 1 | One-cycle shift-complete pulse |
| shift_data_i | input | 8 | Byte held by the external shifter |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| irq_no | output | 1 | Interrupt request, active low |
| shift_start_o | output | 1 | One-cycle pulse that starts a new shift |

## Verification
The hardest case to produce from the ports is a set and a clear that collide in the same cycle. Covering it needs a `shift_done_i` pulse to land in the same cycle as either a flag-clearing write or a shift-data read. The bench raises the pulse inside the write and read tasks themselves, so both collisions occur at a known edge. Edge detection under both polarities is exercised by toggling the line in random bursts, with the polarity re-chosen between them. Each toggle is followed by enough idle cycles to let the synchronizer settle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = DATA_W - 1;
  localparam int SHIFT_BIT = 2;
  localparam int EDGE_BIT = 3;
  localparam int CTRL_RISE_BIT = 6;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_EN   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int  SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      prev_q <= IDLE_LEVEL;
    end else begin
      sync_q <= {sync_q[MSB-1:0], line_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign edge_o = rise_sel_i ? (sync_q[MSB] & ~prev_q) : (~sync_q[MSB] & prev_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          W = 8,
  parameter logic [7:0]  IMPL_MASK = 8'h0C
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-2:0]   set_i,
  input  logic [W-2:0]   clr_i,
  input  logic           en_wr_i,
  input  logic [W-1:0]   en_data_i,
  output logic [W-2:0]   flag_o,
  output logic [W-2:0]   en_o,
  output logic           any_o
);
  localparam int FW = W - 1;
  localparam logic [FW-1:0] IMPL = IMPL_MASK[FW-1:0];

  for (genvar i = 0; i < FW; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic flag_q, en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= 1'b0;
          en_q   <= 1'b0;
        end else begin
          // set wins over clear
          if (set_i[i])      flag_q <= 1'b1;
          else if (clr_i[i]) flag_q <= 1'b0;
          if (en_wr_i && en_data_i[i]) en_q <= en_data_i[W-1];
        end
      end
      assign flag_o[i] = flag_q;
      assign en_o[i]   = en_q;
    end else begin : g_tie
      assign flag_o[i] = 1'b0;
      assign en_o[i]   = 1'b0;
    end
  end

  assign any_o = |(flag_o & en_o);

  assert_en_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && en_data_i[W-1] |=>
      ((en_o & $past(en_data_i[FW-1:0])) == ($past(en_data_i[FW-1:0]) & IMPL)));

  assert_en_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && !en_data_i[W-1] |=> ((en_o & $past(en_data_i[FW-1:0])) == '0));

  assert_flag_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((flag_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              line_i,
  input  logic              shift_done_i,
  input  logic [DATA_W-1:0] shift_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_no,
  output logic              shift_start_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << SHIFT_BIT) | (1 << EDGE_BIT));

  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q;
  logic              edge_evt, data_rd, any_act, start_q;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags, ens;

  assign sel     = reg_sel_e'(addr_i);
  assign data_rd = rd_i && (sel == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (wr_i && sel == SEL_CTRL) ctrl_q <= wr_data_i;
      start_q <= data_rd;
    end
  end

  irq_edge_det #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .rise_sel_i (ctrl_q[CTRL_RISE_BIT]),
    .edge_o     (edge_evt)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SHIFT_BIT] = shift_done_i;
    set_vec[EDGE_BIT]  = edge_evt;
    clr_vec = (wr_i && sel == SEL_FLAG) ? wr_data_i[FLAG_W-1:0] : '0;
    if (data_rd) clr_vec[SHIFT_BIT] = 1'b1;
  end

  irq_flag_bank #(.W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .en_wr_i   (wr_i && sel == SEL_EN),
    .en_data_i (wr_data_i),
    .flag_o    (flags),
    .en_o      (ens),
    .any_o     (any_act)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_data_o = shift_data_i;
      SEL_CTRL: rd_data_o = ctrl_q;
      SEL_FLAG: rd_data_o = {any_act, flags};
      SEL_EN:   rd_data_o = {1'b1, ens};
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_no        = ~any_act;
  assign shift_start_o = start_q;

  assert_start_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd |=> shift_start_o);

  assert_start_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rd |=> !shift_start_o);
endmodule

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, line_i = 1'b1, shift_done_i = 1'b0;
  logic [7:0] shift_data_i = 8'h5A;
  logic [7:0] rd_data_o;
  logic       irq_no, shift_start_o;

  int total = 0, bad = 0;
  logic [7:0] m_en = '0, m_flag = '0, m_ctrl = '0;

  always #2 clk_i = ~clk_i;

  irq_ctl uut (.*);

  function automatic logic [7:0] flag_view();
    return {|(m_flag & m_en), m_flag[6:0]};
  endfunction
  function automatic logic [7:0] en_view();
    return {1'b1, m_en[6:0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic pulse);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_i = 1'b1; shift_done_i = pulse;
    @(negedge clk_i);
    wr_i = 1'b0; shift_done_i = 1'b0;
    if (a == 2'd3) m_en = d[7] ? (m_en | (d & 8'h0C)) : (m_en & ~d);
    if (a == 2'd2) m_flag = m_flag & ~(d & 8'h0C);
    if (a == 2'd1) m_ctrl = d;
    if (pulse) m_flag[2] = 1'b1;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk_i);
    addr_i = a; #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic chk_irq();
    chk("R8", {7'd0, irq_no}, {7'd0, ~|(m_flag & m_en)});
  endtask

  task automatic pulse_done();
    @(negedge clk_i); shift_done_i = 1'b1;
    @(negedge clk_i); shift_done_i = 1'b0;
    m_flag[2] = 1'b1;
  endtask

  task automatic data_read(logic pulse);
    @(negedge clk_i);
    addr_i = 2'd0; rd_i = 1'b1; shift_done_i = pulse; #1;
    chk("R7 data", rd_data_o, shift_data_i);
    @(negedge clk_i);
    rd_i = 1'b0; shift_done_i = 1'b0;
    chk("R7 start", {7'd0, shift_start_o}, 8'd1);
    m_flag[2] = pulse;
    @(negedge clk_i);
    chk("R7 one", {7'd0, shift_start_o}, 8'd0);
  endtask

  task automatic set_line(logic v);
    logic rise;
    rise = m_ctrl[6];
    @(negedge clk_i);
    if (v != line_i && (rise ? v : !v)) m_flag[3] = 1'b1;
    line_i = v;
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    rd_chk("R10 flag", 2'd2, 8'h00);
    rd_chk("R10 en", 2'd3, 8'h80);
    rd_chk("R10 ctrl", 2'd1, 8'h00);
    chk("R10 irq", {7'd0, irq_no}, 8'd1);
    chk("R10 start", {7'd0, shift_start_o}, 8'd0);
    // R1 / R2 / R3
    wr(2'd3, 8'h84, 1'b0); rd_chk("R1", 2'd3, en_view());
    wr(2'd3, 8'h88, 1'b0); rd_chk("R1 keep", 2'd3, 8'h8C);
    wr(2'd3, 8'h04, 1'b0); rd_chk("R2", 2'd3, 8'h88);
    wr(2'd3, 8'hFF, 1'b0); rd_chk("R3", 2'd3, 8'h8C);
    // R6 falling edge with 0x20
    wr(2'd1, 8'h20, 1'b0); rd_chk("R6 ctrl", 2'd1, 8'h20);
    set_line(1'b0); rd_chk("R6 fall", 2'd2, 8'h88);
    chk_irq();
    wr(2'd2, 8'h08, 1'b0); rd_chk("R5", 2'd2, 8'h00);
    set_line(1'b1); rd_chk("R6 no rise", 2'd2, 8'h00);
    wr(2'd1, 8'h40, 1'b0);
    set_line(1'b0); rd_chk("R6 no fall", 2'd2, 8'h00);
    set_line(1'b1); rd_chk("R6 rise", 2'd2, 8'h88);
    wr(2'd2, 8'h08, 1'b0);
    // R4 / R7 shift flag
    pulse_done(); rd_chk("R4 shift", 2'd2, flag_view());
    wr(2'd2, 8'h00, 1'b0); rd_chk("R5 zero", 2'd2, flag_view());
    data_read(1'b0); rd_chk("R7 clr", 2'd2, flag_view());
    // R9 collisions
    pulse_done();
    wr(2'd2, 8'h04, 1'b1); rd_chk("R9 wr", 2'd2, flag_view());
    data_read(1'b1); rd_chk("R9 rd", 2'd2, flag_view());
    wr(2'd2, 8'h0C, 1'b0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: wr(2'd3, 8'($urandom), 1'b0);
        1: wr(2'd2, 8'($urandom), 1'($urandom));
        2: pulse_done();
        3: set_line(~line_i);
        4: wr(2'd1, 8'($urandom), 1'b0);
        5: data_read(1'($urandom));
        default: rd_chk("R3 rnd", 2'd3, en_view());
      endcase
      rd_chk("R4 rnd", 2'd2, flag_view());
      chk_irq();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule